// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks the way to be overwritten when a line is filled into a set-associative cache, and it holds the replacement history that guides that pick. The requester presents a set index together with the set's per-way valid bits and a mask of the ways that can be written right now. In the same cycle it gets back a one-hot victim and a flag that says whether that victim may be used. An empty way always takes precedence over the history-based choice. If the history points at a way that cannot be written this cycle, that choice is dropped and another writable way is used instead.

The replacement history is a three-bit binary tree per set (four ways, sixteen sets by default). Two touch ports update it: one for hits and one for fills. Each port carries a first-issue flag. A touch from a replayed or merged request, which has its flag low, leaves the history as it is, so each access moves the tree at most once. Each touch sets the tree bits on the path to the touched way so that they point to the other half.

Top module: `victim_way_sel`

## Requirements
- R1: After reset every set's tree bits are zero, so with all ways valid and writable the victim of every set is way 0 (`victim_oh` = 4'b0001).
- R2: If at least one way is both invalid and writable, the victim is the lowest-numbered such way, whatever the tree holds.
- R3: If no way is both invalid and writable, the victim is the tree's way when that way is writable. The tree is read as follows: root bit 0 selects ways 0/1 and 1 selects ways 2/3; the left bit then picks way 0 (0) or way 1 (1), and the right bit picks way 2 (0) or way 3 (1).
- R4: A touch of way w with its first-issue flag high updates the tree to point away from w. For w in {0,1} the root becomes 1 and the left bit becomes 1 when w=0 and 0 when w=1. For w in {2,3} the root becomes 0 and the right bit becomes 1 when w=2 and 0 when w=3. The other bit is unchanged. The effect shows at the selector one cycle after the strobe.
- R5: A touch on either port with its first-issue flag low leaves the tree of every set unchanged.
- R6: A fill touch follows the same rule as a hit touch (R4, R5).
- R7: If the tree's way is not writable and R2 does not apply, the victim is the lowest-numbered writable way. The victim is never a way whose writable bit is low.
- R8: If no way is writable, `victim_ok` is 0 and `victim_oh` is all zeros.
- R9: If a hit touch and a fill touch reach the same set in the same cycle, the hit is applied first and the fill second.
- R10: A touch changes only the tree of its own set.
- R11: `victim_oh` has at most one bit set, and `victim_ok` is 1 exactly when it has one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pick_set | input | 4 | Set whose victim is requested |
| way_valid | input | 4 | Valid bit of each way in `pick_set` |
| way_writable | input | 4 | Ways that can be written this cycle |
| victim_oh | output | 4 | One-hot victim way (zero when none) |
| victim_ok | output | 1 | Victim may be used |
| acc_valid | input | 1 | Hit touch strobe |
| acc_first | input | 1 | Hit touch is a first issue |
| acc_set | input | 4 | Set of the hit touch |
| acc_way | input | 2 | Way of the hit touch |
| fill_valid | input | 1 | Fill touch strobe |
| fill_first | input | 1 | Fill touch is a first issue |
| fill_set | input | 4 | Set of the fill touch |
| fill_way | input | 2 | Way of the fill touch |

## Verification
On every cycle the assertions check the shape of the victim output. They also check that empty writable ways win, that a way that cannot be written is never returned, that the selector reports failure when no way can be written, and that touches with the first-issue flag low leave the stored trees alone. The direction each tree bit takes after a touch, the order of two touches to one set in the same cycle, the independence of the sets and the exact fallback way all depend on the history. Those are shown only by the bench's sweeps, which run every touch on every set and every valid/writable combination against four tree states.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    parameter int unsigned NUM_WAYS = 4;
    parameter int unsigned NUM_SETS = 16;

    localparam int unsigned WAY_W  = $clog2(NUM_WAYS);
    localparam int unsigned SET_W  = $clog2(NUM_SETS);
    localparam int unsigned TREE_W = NUM_WAYS - 1;
    localparam int unsigned LEVELS = WAY_W;

    typedef logic [NUM_WAYS-1:0] way_mask_t;
    typedef logic [WAY_W-1:0]    way_idx_t;
    typedef logic [SET_W-1:0]    set_idx_t;
    typedef logic [TREE_W-1:0]   tree_t;

    // A touch request after gating by the first-issue flag
    typedef struct packed {
        logic     en;
        set_idx_t set;
        way_idx_t way;
    } touch_t;

    // Where the victim came from
    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_INVALID = 2'd1,
        PICK_TREE    = 2'd2,
        PICK_SPARE   = 2'd3
    } pick_src_t;

    // Walk the heap-ordered tree: bit 0 of a node goes to the lower half
    function automatic way_idx_t tree_victim(input tree_t t);
        way_idx_t w;
        int unsigned node;
        logic b;
        w    = '0;
        node = 0;
        for (int unsigned lvl = 0; lvl < LEVELS; lvl++) begin
            b = t[node];
            w[WAY_W-1-lvl] = b;
            node = 2 * node + 1 + (b ? 1 : 0);
        end
        return w;
    endfunction

    // Point every node on the path away from the touched way
    function automatic tree_t tree_touch(input tree_t t, input way_idx_t w);
        tree_t r;
        int unsigned node;
        logic b;
        r    = t;
        node = 0;
        for (int unsigned lvl = 0; lvl < LEVELS; lvl++) begin
            b = w[WAY_W-1-lvl];
            r[node] = ~b;
            node = 2 * node + 1 + (b ? 1 : 0);
        end
        return r;
    endfunction

    function automatic way_mask_t lowest_oh(input way_mask_t m);
        way_mask_t neg;
        neg = ~m + way_mask_t'(1);
        return m & neg;
    endfunction

    function automatic way_mask_t idx_to_oh(input way_idx_t w);
        return way_mask_t'(1) << w;
    endfunction

endpackage

// File: rtl/vsel_touch_gate.sv
module vsel_touch_gate
    import vsel_pkg::*;
(
    input  logic     strobe,
    input  logic     first_issue,
    input  set_idx_t set_in,
    input  way_idx_t way_in,
    output touch_t   touch
);
    // Replays and merged requests must not move the history
    always_comb begin
        touch.en  = strobe & first_issue;
        touch.set = set_in;
        touch.way = way_in;
    end
endmodule

// File: rtl/vsel_plru_store.sv
module vsel_plru_store
    import vsel_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  touch_t                     hit_touch,
    input  touch_t                     fill_touch,
    input  set_idx_t                   rd_set,
    output tree_t                      rd_tree,
    output logic [NUM_SETS*TREE_W-1:0] state_flat
);
    tree_t trees [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        tree_t nxt;
        logic  hit_here;
        logic  fill_here;

        assign hit_here  = hit_touch.en  && (hit_touch.set  == set_idx_t'(s));
        assign fill_here = fill_touch.en && (fill_touch.set == set_idx_t'(s));

        // Hit first, fill second when both land on this set
        always_comb begin
            nxt = trees[s];
            if (hit_here)  nxt = tree_touch(nxt, hit_touch.way);
            if (fill_here) nxt = tree_touch(nxt, fill_touch.way);
        end

        always_ff @(posedge clk) begin
            if (rst) trees[s] <= '0;
            else     trees[s] <= nxt;
        end

        assign state_flat[s*TREE_W +: TREE_W] = trees[s];
    end

    assign rd_tree = trees[rd_set];
endmodule

// File: rtl/vsel_victim_pick.sv
module vsel_victim_pick
    import vsel_pkg::*;
(
    input  way_mask_t valid,
    input  way_mask_t writable,
    input  tree_t     tree,
    output way_mask_t victim,
    output logic      ok,
    output pick_src_t src
);
    way_mask_t empty_wr;
    way_mask_t tree_oh;

    assign empty_wr = ~valid & writable;
    assign tree_oh  = idx_to_oh(tree_victim(tree));

    always_comb begin
        if (|empty_wr) begin
            victim = lowest_oh(empty_wr);
            src    = PICK_INVALID;
        end else if (|(tree_oh & writable)) begin
            victim = tree_oh;
            src    = PICK_TREE;
        end else if (|writable) begin
            victim = lowest_oh(writable);
            src    = PICK_SPARE;
        end else begin
            victim = '0;
            src    = PICK_NONE;
        end
    end

    assign ok = (src != PICK_NONE);
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
    import vsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SET_W-1:0]     pick_set,
    input  logic [NUM_WAYS-1:0]  way_valid,
    input  logic [NUM_WAYS-1:0]  way_writable,
    output logic [NUM_WAYS-1:0]  victim_oh,
    output logic                 victim_ok,
    input  logic                 acc_valid,
    input  logic                 acc_first,
    input  logic [SET_W-1:0]     acc_set,
    input  logic [WAY_W-1:0]     acc_way,
    input  logic                 fill_valid,
    input  logic                 fill_first,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [WAY_W-1:0]     fill_way
);
    touch_t                     hit_t;
    touch_t                     fill_t;
    tree_t                      cur_tree;
    pick_src_t                  pick_src;
    logic [NUM_SETS*TREE_W-1:0] state_flat;

    vsel_touch_gate u_hit_gate (
        .strobe      (acc_valid),
        .first_issue (acc_first),
        .set_in      (acc_set),
        .way_in      (acc_way),
        .touch       (hit_t)
    );

    vsel_touch_gate u_fill_gate (
        .strobe      (fill_valid),
        .first_issue (fill_first),
        .set_in      (fill_set),
        .way_in      (fill_way),
        .touch       (fill_t)
    );

    vsel_plru_store u_store (
        .clk        (clk),
        .rst        (rst),
        .hit_touch  (hit_t),
        .fill_touch (fill_t),
        .rd_set     (pick_set),
        .rd_tree    (cur_tree),
        .state_flat (state_flat)
    );

    vsel_victim_pick u_pick (
        .valid    (way_valid),
        .writable (way_writable),
        .tree     (cur_tree),
        .victim   (victim_oh),
        .ok       (victim_ok),
        .src      (pick_src)
    );
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker
    import vsel_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_WAYS-1:0]        way_valid,
    input logic [NUM_WAYS-1:0]        way_writable,
    input logic [NUM_WAYS-1:0]        victim_oh,
    input logic                       victim_ok,
    input logic                       acc_valid,
    input logic                       acc_first,
    input logic                       fill_valid,
    input logic                       fill_first,
    input logic [NUM_SETS*TREE_W-1:0] state_flat
);
    AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(victim_oh)); // R11

    AST_OK_MATCHES_OH: assert property (@(posedge clk) disable iff (rst)
        victim_ok == ($countones(victim_oh) == 1)); // R11

    AST_EMPTY_WINS: assert property (@(posedge clk) disable iff (rst)
        (|(~way_valid & way_writable)) |-> ((victim_oh & way_valid) == '0 && victim_ok)); // R2

    AST_NEVER_UNWRITABLE: assert property (@(posedge clk) disable iff (rst)
        (victim_oh & ~way_writable) == '0); // R7

    AST_NONE_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        (way_writable == '0) |-> !victim_ok); // R8

    AST_REPLAY_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (!(acc_valid && acc_first) && !(fill_valid && fill_first)) |=> $stable(state_flat)); // R5
endmodule

bind victim_way_sel vsel_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .way_valid    (way_valid),
    .way_writable (way_writable),
    .victim_oh    (victim_oh),
    .victim_ok    (victim_ok),
    .acc_valid    (acc_valid),
    .acc_first    (acc_first),
    .fill_valid   (fill_valid),
    .fill_first   (fill_first),
    .state_flat   (state_flat)
);

// File: tb/tb_victim_way_sel.sv
`timescale 1ns/1ps
module tb_victim_way_sel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pick_set = '0;
    logic [3:0] way_valid = '0;
    logic [3:0] way_writable = '0;
    logic [3:0] victim_oh;
    logic       victim_ok;
    logic       acc_valid = 1'b0;
    logic       acc_first = 1'b0;
    logic [3:0] acc_set = '0;
    logic [1:0] acc_way = '0;
    logic       fill_valid = 1'b0;
    logic       fill_first = 1'b0;
    logic [3:0] fill_set = '0;
    logic [1:0] fill_way = '0;

    int checks = 0;
    int failures = 0;
    logic [2:0] mdl [16];

    always #4 clk = ~clk;

    victim_way_sel dut (
        .clk(clk), .rst(rst), .pick_set(pick_set), .way_valid(way_valid),
        .way_writable(way_writable), .victim_oh(victim_oh), .victim_ok(victim_ok),
        .acc_valid(acc_valid), .acc_first(acc_first), .acc_set(acc_set), .acc_way(acc_way),
        .fill_valid(fill_valid), .fill_first(fill_first), .fill_set(fill_set), .fill_way(fill_way)
    );

    // Bench model: bit0 root, bit1 left (ways 0/1), bit2 right (ways 2/3)
    function automatic int model_tree_way(input logic [2:0] t);
        if (t[0]) return 2 + (t[2] ? 1 : 0);
        return t[1] ? 1 : 0;
    endfunction

    function automatic logic [2:0] model_touch(input logic [2:0] t, input int w);
        logic [2:0] r;
        r = t;
        if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
        else       begin r[0] = 1'b0; r[2] = (w == 2); end
        return r;
    endfunction

    function automatic logic [4:0] model_pick(input logic [3:0] v, input logic [3:0] wr,
                                              input logic [2:0] t);
        int tw;
        for (int i = 0; i < 4; i++)
            if (!v[i] && wr[i]) return {1'b1, 4'(1 << i)};
        tw = model_tree_way(t);
        if (wr[tw]) return {1'b1, 4'(1 << tw)};
        for (int i = 0; i < 4; i++)
            if (wr[i]) return {1'b1, 4'(1 << i)};
        return 5'b0;
    endfunction

    task automatic check_pick(input int s, input logic [3:0] v, input logic [3:0] wr,
                              input string req);
        logic [4:0] exp;
        pick_set = 4'(s); way_valid = v; way_writable = wr;
        #1;
        exp = model_pick(v, wr, mdl[s]);
        checks++;
        if ({victim_ok, victim_oh} !== exp) begin
            failures++;
            $display("FAIL %s set=%0d valid=%b wr=%b actual ok=%b oh=%b expected ok=%b oh=%b",
                     req, s, v, wr, victim_ok, victim_oh, exp[4], exp[3:0]);
        end
    endtask

    task automatic check_all_sets(input string req);
        for (int s = 0; s < 16; s++) check_pick(s, 4'hF, 4'hF, req);
    endtask

    // Drive one cycle of touches at the falling edge; model follows R4/R5/R9
    task automatic touch(input logic av, input logic af, input int as, input int aw,
                         input logic fv, input logic ff, input int fs, input int fw);
        @(negedge clk);
        acc_valid = av; acc_first = af; acc_set = 4'(as); acc_way = 2'(aw);
        fill_valid = fv; fill_first = ff; fill_set = 4'(fs); fill_way = 2'(fw);
        if (av && af) mdl[as] = model_touch(mdl[as], aw);
        if (fv && ff) mdl[fs] = model_touch(mdl[fs], fw);
        @(negedge clk);
        acc_valid = 1'b0; fill_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) mdl[s] = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, every set picks way 0
        check_all_sets("R1");

        // R4 on the hit port: every way on every set, then all sets (R10)
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 4; w++) begin
                touch(1'b1, 1'b1, s, w, 1'b0, 1'b0, 0, 0);
                check_pick(s, 4'hF, 4'hF, "R4");
            end
        end
        for (int s = 0; s < 16; s++) begin
            touch(1'b1, 1'b1, s, s % 4, 1'b0, 1'b0, 0, 0);
            check_all_sets("R10");
        end

        // R6: fill port applies the same rule
        for (int s = 0; s < 16; s++) begin
            for (int w = 3; w >= 0; w--) begin
                touch(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, s, w);
                check_pick(s, 4'hF, 4'hF, "R6");
            end
        end

        // R5: replays on either port change nothing
        for (int s = 0; s < 16; s++) begin
            touch(1'b1, 1'b0, s, (s + 1) % 4, 1'b1, 1'b0, 15 - s, s % 4);
            check_all_sets("R5");
        end

        // R9: both ports on one set in one cycle, all way pairs
        for (int a = 0; a < 4; a++) begin
            for (int f = 0; f < 4; f++) begin
                touch(1'b1, 1'b1, 7, a, 1'b1, 1'b1, 7, f);
                check_pick(7, 4'hF, 4'hF, "R9");
                touch(1'b1, 1'b1, 8, a, 1'b1, 1'b1, 9, f);
                check_pick(8, 4'hF, 4'hF, "R10");
                check_pick(9, 4'hF, 4'hF, "R10");
            end
        end

        // R2/R3/R7/R8: every valid/writable pattern under four tree states
        for (int w = 0; w < 4; w++) begin
            touch(1'b1, 1'b1, 5, w, 1'b0, 1'b0, 0, 0);
            for (int v = 0; v < 16; v++) begin
                for (int wr = 0; wr < 16; wr++) begin
                    if (wr == 0)
                        check_pick(5, 4'(v), 4'(wr), "R8");
                    else if (|(~4'(v) & 4'(wr)))
                        check_pick(5, 4'(v), 4'(wr), "R2");
                    else if (wr[model_tree_way(mdl[5])])
                        check_pick(5, 4'(v), 4'(wr), "R3");
                    else
                        check_pick(5, 4'(v), 4'(wr), "R7");
                end
            end
        end

        // R11: output shape across the sweep is covered by the exact compare above
        check_pick(5, 4'h0, 4'h0, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule